// File: doc/BRIEF.md
# Dual-Bank CPU Register File with Single-Cycle Exchanges

This block is the register store of an 8-bit processor core. It keeps an accumulator/flags pair and three general pairs (BC, DE, HL), a second shadow copy of those four pairs, two index registers (IX, IY) and a stack pointer (SP). Surrounding control logic reads any byte register or any pair combinationally. It writes one byte and one pair per clock, and it can issue exchange commands and a stack-pointer load in the same clock.

The exchanges do not move data. Small bank-select state decides which physical word answers to each architectural name. There is a bit for the accumulator/flags pair, a bit for the general group, and one DE/HL swap bit per general bank. An exchange flips a bit, so every swap takes one cycle, whatever the register contents are. All pins are plain control and data. The block accepts a command on every clock and has no back-pressure, so it has no valid/ready handshake.

Top module: `shadow_regfile`

## Requirements
- R1: While reset is low and after it is released, every register, every shadow and every bank-select bit reads zero. The reset is synchronous and active low.
- R2: Byte codes are A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7. A byte write updates only the addressed byte. A byte read returns that byte in the same cycle it is selected.
- R3: Pair codes are AF=0, BC=1, DE=2, HL=3, IX=4, IY=5, SP=6. The first-named register is the high byte. A pair write sets both bytes. A pair read combines the two bytes of the pair, so a pair-to-pair copy done as two byte writes shows up in the target pair.
- R4: A DE/HL swap exchanges the full 16-bit values of DE and HL. Two swaps in a row restore them.
- R5: An AF swap exchanges AF with its shadow and alters no other register.
- R6: A bank swap exchanges BC, DE and HL with their shadows as a set. It leaves AF and the AF shadow unchanged, and each bank keeps its own DE/HL arrangement.
- R7: No exchange writes storage, and no exchange changes F except the AF swap. Any sequence of exchanges matches an equivalent sequence of value swaps.
- R8: A stack load with source code HL=0, IX=1 or IY=2 copies that register into SP in the next cycle. No byte code reaches SP.
- R9: Within a cycle, the AF and bank swaps take effect first, then the DE/HL swap acts on the newly active bank, and then the writes land on the registers named after those exchanges. The stack load takes its source value as it stood before the cycle.
- R10: When writes in one cycle collide, a byte write overrides the same byte of a pair write, and a stack load overrides a pair write to SP.
- R11: Pair code 7 reads zero and is ignored on writes. Stack-load source code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd8_sel | input | 3 | Byte read select (byte code) |
| rd8_data | output | DW | Byte read data, combinational |
| rd16_sel | input | 3 | Pair read select (pair code) |
| rd16_data | output | 2*DW | Pair read data, combinational |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write target (byte code) |
| wr8_data | input | DW | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 3 | Pair write target (pair code) |
| wr16_data | input | 2*DW | Pair write data |
| xchg_af | input | 1 | Swap AF with its shadow |
| xchg_bank | input | 1 | Swap BC, DE, HL with their shadows |
| xchg_dehl | input | 1 | Swap DE and HL in the active bank |
| sp_load_en | input | 1 | Load SP from the chosen source |
| sp_load_src | input | 2 | Stack-load source code |

## Verification
Reads have zero latency: a change of rd8_sel or rd16_sel shows on the data outputs in the same cycle. Writes, exchanges and stack loads are registered once and become visible immediately after the next rising edge. The bench drives each command on a falling edge and advances its value model at the following rising edge. It then returns every command input to idle, so the state stays frozen while it sweeps all read selects and samples each one a time unit after changing the select.

// File: rtl/srf_pkg.sv
package srf_pkg;

  // Pair codes (high byte first)
  localparam logic [2:0] PC_AF   = 3'd0;
  localparam logic [2:0] PC_BC   = 3'd1;
  localparam logic [2:0] PC_DE   = 3'd2;
  localparam logic [2:0] PC_HL   = 3'd3;
  localparam logic [2:0] PC_IX   = 3'd4;
  localparam logic [2:0] PC_IY   = 3'd5;
  localparam logic [2:0] PC_SP   = 3'd6;
  localparam logic [2:0] PC_NONE = 3'd7;

  // Stack-load source codes
  localparam logic [1:0] SPS_HL   = 2'd0;
  localparam logic [1:0] SPS_IX   = 2'd1;
  localparam logic [1:0] SPS_IY   = 2'd2;
  localparam logic [1:0] SPS_NONE = 2'd3;

  // Physical storage layout
  localparam int NUM_BANK  = 2;
  localparam int GRP_SLOTS = 3;
  localparam int E_AF0     = 0;
  localparam int E_GRP0    = E_AF0 + NUM_BANK;
  localparam int E_IX      = E_GRP0 + NUM_BANK * GRP_SLOTS;
  localparam int E_IY      = E_IX + 1;
  localparam int E_SP      = E_IY + 1;
  localparam int NENT      = E_SP + 1;
  localparam int IDX_W     = $clog2(NENT);

  typedef struct packed {
    logic       af;    // active accumulator/flags bank
    logic       grp;   // active general bank
    logic [1:0] dehl;  // per-bank DE/HL swap state
  } bank_t;

  function automatic logic [IDX_W-1:0] grp_entry(input logic bank, input logic [1:0] slot);
    return IDX_W'(E_GRP0) + (bank ? IDX_W'(GRP_SLOTS) : IDX_W'(0)) + IDX_W'(slot);
  endfunction

  // Map an architectural pair name to its physical word under a bank state
  function automatic logic [IDX_W-1:0] pair_entry(input bank_t b, input logic [2:0] code);
    logic sw;
    sw = b.dehl[b.grp];
    case (code)
      PC_AF:   return b.af ? IDX_W'(E_AF0 + 1) : IDX_W'(E_AF0);
      PC_BC:   return grp_entry(b.grp, 2'd0);
      PC_DE:   return grp_entry(b.grp, sw ? 2'd2 : 2'd1);
      PC_HL:   return grp_entry(b.grp, sw ? 2'd1 : 2'd2);
      PC_IX:   return IDX_W'(E_IX);
      PC_IY:   return IDX_W'(E_IY);
      default: return IDX_W'(E_SP);
    endcase
  endfunction

endpackage

// File: rtl/srf_bank_ctl.sv
module srf_bank_ctl
  import srf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  xchg_af,
  input  logic  xchg_bank,
  input  logic  xchg_dehl,
  output bank_t cur_o,
  output bank_t nxt_o
);

  bank_t cur_q, nxt;

  always_comb begin
    nxt      = cur_q;
    nxt.af   = cur_q.af ^ xchg_af;
    nxt.grp  = cur_q.grp ^ xchg_bank;
    if (xchg_dehl)
      nxt.dehl[nxt.grp] = ~cur_q.dehl[nxt.grp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign cur_o = cur_q;
  assign nxt_o = nxt;

endmodule

// File: rtl/srf_storage.sv
module srf_storage #(
  parameter int DW   = 8,
  parameter int NENT = 11,
  parameter int NWP  = 3,
  parameter int IW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWP-1:0]         we_hi,
  input  logic [NWP-1:0]         we_lo,
  input  logic [NWP*IW-1:0]      widx,
  input  logic [NWP*2*DW-1:0]    wdata,
  output logic [NENT*2*DW-1:0]   q_flat
);

  localparam int PW = 2 * DW;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [PW-1:0] q, d;

    // Higher-numbered write ports win on the same byte
    always_comb begin
      d = q;
      for (int p = 0; p < NWP; p++) begin
        if (widx[p*IW +: IW] == IW'(e)) begin
          if (we_hi[p]) d[PW-1:DW] = wdata[p*PW+DW +: DW];
          if (we_lo[p]) d[DW-1:0]  = wdata[p*PW +: DW];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign q_flat[e*PW +: PW] = q;
  end

endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      rd8_sel,
  output logic [DW-1:0]   rd8_data,
  input  logic [2:0]      rd16_sel,
  output logic [2*DW-1:0] rd16_data,
  input  logic            wr8_en,
  input  logic [2:0]      wr8_sel,
  input  logic [DW-1:0]   wr8_data,
  input  logic            wr16_en,
  input  logic [2:0]      wr16_sel,
  input  logic [2*DW-1:0] wr16_data,
  input  logic            xchg_af,
  input  logic            xchg_bank,
  input  logic            xchg_dehl,
  input  logic            sp_load_en,
  input  logic [1:0]      sp_load_src
);

  localparam int PW    = 2 * DW;
  localparam int NWP   = 3;      // 0: pair, 1: stack load, 2: byte
  localparam int WP_PR = 0;
  localparam int WP_SP = 1;
  localparam int WP_BY = 2;

  bank_t bank_cur, bank_nxt;
  logic [NENT*PW-1:0]  q_flat;
  logic [NWP-1:0]      we_hi, we_lo;
  logic [NWP*IDX_W-1:0] widx;
  logic [NWP*PW-1:0]   wdata;

  srf_bank_ctl u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .xchg_af   (xchg_af),
    .xchg_bank (xchg_bank),
    .xchg_dehl (xchg_dehl),
    .cur_o     (bank_cur),
    .nxt_o     (bank_nxt)
  );

  srf_storage #(.DW(DW), .NENT(NENT), .NWP(NWP), .IW(IDX_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_hi  (we_hi),
    .we_lo  (we_lo),
    .widx   (widx),
    .wdata  (wdata),
    .q_flat (q_flat)
  );

  // Reads: current mapping, current contents
  logic [IDX_W-1:0] rd16_idx, rd8_idx;
  logic [PW-1:0]    rd8_word;

  always_comb begin
    rd16_idx  = pair_entry(bank_cur, rd16_sel);
    rd16_data = (rd16_sel == PC_NONE) ? '0 : q_flat[int'(rd16_idx)*PW +: PW];
    rd8_idx   = pair_entry(bank_cur, {1'b0, rd8_sel[2:1]});
    rd8_word  = q_flat[int'(rd8_idx)*PW +: PW];
    rd8_data  = rd8_sel[0] ? rd8_word[DW-1:0] : rd8_word[PW-1:DW];
  end

  // Stack-load source: value before this cycle's exchanges and writes
  logic [IDX_W-1:0] sp_src_idx;
  logic             sp_go;

  always_comb begin
    case (sp_load_src)
      SPS_IX:  sp_src_idx = IDX_W'(E_IX);
      SPS_IY:  sp_src_idx = IDX_W'(E_IY);
      default: sp_src_idx = pair_entry(bank_cur, PC_HL);
    endcase
    sp_go = sp_load_en && (sp_load_src != SPS_NONE);
  end

  // Write ports: targets resolved with the post-exchange mapping
  logic pr_go;
  assign pr_go = wr16_en && (wr16_sel != PC_NONE);

  always_comb begin
    we_hi[WP_PR] = pr_go;
    we_lo[WP_PR] = pr_go;
    widx[WP_PR*IDX_W +: IDX_W] = pair_entry(bank_nxt, wr16_sel);
    wdata[WP_PR*PW +: PW]      = wr16_data;

    we_hi[WP_SP] = sp_go;
    we_lo[WP_SP] = sp_go;
    widx[WP_SP*IDX_W +: IDX_W] = IDX_W'(E_SP);
    wdata[WP_SP*PW +: PW]      = q_flat[int'(sp_src_idx)*PW +: PW];

    we_hi[WP_BY] = wr8_en && !wr8_sel[0];
    we_lo[WP_BY] = wr8_en &&  wr8_sel[0];
    widx[WP_BY*IDX_W +: IDX_W] = pair_entry(bank_nxt, {1'b0, wr8_sel[2:1]});
    wdata[WP_BY*PW +: PW]      = {wr8_data, wr8_data};
  end

endmodule

// File: rtl/srf_checker.sv
module srf_checker
  import srf_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  xchg_af,
  input logic                  xchg_bank,
  input logic                  xchg_dehl,
  input logic                  wr8_en,
  input logic                  wr16_en,
  input logic                  sp_load_en,
  input logic [1:0]            sp_load_src,
  input bank_t                 bank,
  input logic [NENT*2*DW-1:0]  q_flat
);

  localparam int PW = 2 * DW;

  // R1: state is clear in the first cycle out of reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bank == '0 && q_flat == '0));

  // R5: an AF swap flips the active accumulator/flags bank
  p_af_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_af |=> (bank.af != $past(bank.af)));

  // R6: without an AF swap the accumulator/flags bank holds
  p_af_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_af |=> $stable(bank.af));

  // R6: a bank swap flips the general bank
  p_grp_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_bank |=> (bank.grp != $past(bank.grp)));

  // R4: a lone DE/HL swap changes exactly one swap bit
  p_dehl_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_dehl && !xchg_bank) |=> ($countones(bank.dehl ^ $past(bank.dehl)) == 1));

  // R7: with no writes, storage never changes (exchanges copy nothing)
  p_no_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr8_en && !wr16_en && !sp_load_en) |=> $stable(q_flat));

  // R8: stack load from IX
  p_sp_from_ix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_load_en && sp_load_src == SPS_IX) |=>
      (q_flat[E_SP*PW +: PW] == $past(q_flat[E_IX*PW +: PW])));

endmodule

bind shadow_regfile srf_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xchg_af     (xchg_af),
  .xchg_bank   (xchg_bank),
  .xchg_dehl   (xchg_dehl),
  .wr8_en      (wr8_en),
  .wr16_en     (wr16_en),
  .sp_load_en  (sp_load_en),
  .sp_load_src (sp_load_src),
  .bank        (bank_cur),
  .q_flat      (q_flat)
);

// File: tb/shadow_regfile_tb.sv
module shadow_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk, rst_n;
  logic [2:0] rd8_sel, rd16_sel, wr8_sel, wr16_sel;
  logic [7:0] rd8_data, wr8_data;
  logic [15:0] rd16_data, wr16_data;
  logic wr8_en, wr16_en, xchg_af, xchg_bank, xchg_dehl, sp_load_en;
  logic [1:0] sp_load_src;
  int n_checks = 0, n_fail = 0;

  shadow_regfile #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd8_sel(rd8_sel), .rd8_data(rd8_data),
    .rd16_sel(rd16_sel), .rd16_data(rd16_data), .wr8_en(wr8_en),
    .wr8_sel(wr8_sel), .wr8_data(wr8_data), .wr16_en(wr16_en),
    .wr16_sel(wr16_sel), .wr16_data(wr16_data), .xchg_af(xchg_af),
    .xchg_bank(xchg_bank), .xchg_dehl(xchg_dehl), .sp_load_en(sp_load_en),
    .sp_load_src(sp_load_src)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Value model: architectural names, swaps move values
  logic [15:0] m_af, m_af2, m_bc, m_bc2, m_de, m_de2, m_hl, m_hl2, m_ix, m_iy, m_sp;

  function automatic logic [15:0] m_pair(input logic [2:0] c);
    case (c)
      3'd0: return m_af;  3'd1: return m_bc;  3'd2: return m_de;
      3'd3: return m_hl;  3'd4: return m_ix;  3'd5: return m_iy;
      3'd6: return m_sp;  default: return 16'h0;
    endcase
  endfunction

  function automatic logic [7:0] m_byte(input logic [2:0] c);
    logic [15:0] w;
    w = m_pair({1'b0, c[2:1]});
    return c[0] ? w[7:0] : w[15:8];
  endfunction

  task automatic m_set(input logic [2:0] c, input logic [15:0] v);
    case (c)
      3'd0: m_af = v;  3'd1: m_bc = v;  3'd2: m_de = v;  3'd3: m_hl = v;
      3'd4: m_ix = v;  3'd5: m_iy = v;  3'd6: m_sp = v;  default: ;
    endcase
  endtask

  task automatic m_clear();
    {m_af, m_af2, m_bc, m_bc2, m_de, m_de2, m_hl, m_hl2, m_ix, m_iy, m_sp} = '0;
  endtask

  task automatic m_step(input logic xa, xb, xd, w8e, input logic [2:0] w8s,
                        input logic [7:0] w8d, input logic w16e, input logic [2:0] w16s,
                        input logic [15:0] w16d, input logic spe, input logic [1:0] sps);
    logic [15:0] hl0, ix0, iy0, t;
    hl0 = m_hl; ix0 = m_ix; iy0 = m_iy;
    if (xa) begin t = m_af; m_af = m_af2; m_af2 = t; end
    if (xb) begin
      t = m_bc; m_bc = m_bc2; m_bc2 = t;
      t = m_de; m_de = m_de2; m_de2 = t;
      t = m_hl; m_hl = m_hl2; m_hl2 = t;
    end
    if (xd) begin t = m_de; m_de = m_hl; m_hl = t; end
    if (w16e) m_set(w16s, w16d);
    if (spe) case (sps)
      2'd0: m_sp = hl0;  2'd1: m_sp = ix0;  2'd2: m_sp = iy0;  default: ;
    endcase
    if (w8e) begin
      t = m_pair({1'b0, w8s[2:1]});
      if (w8s[0]) t[7:0] = w8d; else t[15:8] = w8d;
      m_set({1'b0, w8s[2:1]}, t);
    end
  endtask

  task automatic idle();
    {xchg_af, xchg_bank, xchg_dehl, wr8_en, wr16_en, sp_load_en} = '0;
    wr8_sel = 3'd0; wr8_data = 8'h0; wr16_sel = 3'd0; wr16_data = 16'h0; sp_load_src = 2'd0;
  endtask

  task automatic step(input logic xa, xb, xd, w8e, input logic [2:0] w8s,
                      input logic [7:0] w8d, input logic w16e, input logic [2:0] w16s,
                      input logic [15:0] w16d, input logic spe, input logic [1:0] sps);
    @(negedge clk);
    xchg_af = xa; xchg_bank = xb; xchg_dehl = xd;
    wr8_en = w8e; wr8_sel = w8s; wr8_data = w8d;
    wr16_en = w16e; wr16_sel = w16s; wr16_data = w16d;
    sp_load_en = spe; sp_load_src = sps;
    @(posedge clk);
    m_step(xa, xb, xd, w8e, w8s, w8d, w16e, w16s, w16d, spe, sps);
    #1 idle();
  endtask

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Inputs are idle, so state is frozen while every select is swept
  task automatic check_all(input string tag);
    for (int p = 0; p < 8; p++) begin
      rd16_sel = 3'(p); #1;
      chk(tag, $sformatf("pair%0d", p), rd16_data, m_pair(3'(p)));
    end
    for (int b = 0; b < 8; b++) begin
      rd8_sel = 3'(b); #1;
      chk(tag, $sformatf("byte%0d", b), {8'h0, rd8_data}, {8'h0, m_byte(3'(b))});
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); rd8_sel = 3'd0; rd16_sel = 3'd0; m_clear();
    void'($urandom(32'h0005_eed1));
    repeat (3) @(posedge clk);
    #1 check_all("R1");            // values while reset is held
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check_all("R1");

    // R2: byte writes to each code
    for (int b = 0; b < 8; b++)
      step(0,0,0, 1,3'(b),8'(8'h11*(b+1)), 0,3'd0,16'h0, 0,2'd0);
    check_all("R2");

    // R3: pair writes, then a DE <- BC copy done as two byte writes
    for (int p = 0; p < 7; p++)
      step(0,0,0, 0,3'd0,8'h0, 1,3'(p),16'(16'hA101 + p*16'h0202), 0,2'd0);
    check_all("R3");
    step(0,0,0, 1,3'd4,m_byte(3'd2), 0,3'd0,16'h0, 0,2'd0);
    step(0,0,0, 1,3'd5,m_byte(3'd3), 0,3'd0,16'h0, 0,2'd0);
    chk("R3", "copy", m_de, m_bc);
    check_all("R3");

    // R4: DE/HL swap, twice
    step(0,0,1, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R4");
    step(0,0,1, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R4");

    // R5: AF swap, fill shadow AF, swap back
    step(1,0,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R5");
    step(0,0,0, 0,3'd0,8'h0, 1,3'd0,16'h5AF0, 0,2'd0);
    step(1,0,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R5");

    // R6: bank swap keeps AF, per-bank DE/HL state survives
    step(0,1,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R6");
    step(0,0,0, 0,3'd0,8'h0, 1,3'd2,16'hD0E2, 0,2'd0);
    step(0,0,0, 0,3'd0,8'h0, 1,3'd3,16'hB1C2, 0,2'd0);
    step(0,0,1, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0);
    step(0,1,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R6");
    step(0,1,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R6");

    // R7: exchanges leave F alone; all three swaps together
    step(0,1,1, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R7");
    step(1,1,1, 0,3'd0,8'h0, 0,3'd0,16'h0, 0,2'd0); check_all("R7");

    // R8: stack loads from each source
    step(0,0,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 1,2'd0); check_all("R8");
    step(0,0,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 1,2'd1); check_all("R8");
    step(0,0,0, 0,3'd0,8'h0, 0,3'd0,16'h0, 1,2'd2); check_all("R8");

    // R9: writes land after exchanges, stack load sees old HL
    step(0,1,0, 0,3'd0,8'h0, 1,3'd2,16'h9D9E, 0,2'd0); check_all("R9");
    step(0,0,1, 1,3'd6,8'h77, 0,3'd0,16'h0, 0,2'd0); check_all("R9");
    step(1,1,1, 1,3'd1,8'h3C, 1,3'd3,16'h4321, 1,2'd0); check_all("R9");

    // R10: write collisions
    step(0,0,0, 1,3'd7,8'hEE, 1,3'd3,16'h1234, 0,2'd0);
    chk("R10", "HL", m_hl, 16'h12EE); check_all("R10");
    step(0,0,0, 0,3'd0,8'h0, 1,3'd6,16'hFFFF, 1,2'd1); check_all("R10");

    // R11: reserved codes
    step(0,0,0, 0,3'd0,8'h0, 1,3'd7,16'hBEEF, 1,2'd3); check_all("R11");

    // Random mix against the model
    for (int i = 0; i < 500; i++) begin
      step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, 3'($urandom), 8'($urandom),
           ($urandom % 3) == 0, 3'($urandom), 16'($urandom),
           ($urandom % 4) == 0, 2'($urandom));
      check_all("R7");
    end

    summary();
    $finish;
  end

endmodule